// File: doc/BRIEF.md
# Multi-Cycle Load/Store Integer Core

This block is a small sequential processor that runs a six-instruction slice of a 64-bit RISC instruction set in which instruction bits are numbered from the most significant end. It handles add-immediate, register OR, word load with zero fill, word store, word store that writes its address back to the base register, and a conditional branch through a link register. It holds thirty-two 64-bit general registers, a program counter, a count register, a link register and a fixed condition word.

Each instruction moves through fetch, execute and, for loads and stores, a memory phase. All three phases share one word-wide memory port with separate read and write strobes. A ready input completes each access, and the core holds the request steady until it arrives. When the core meets an instruction it cannot decode, it raises a sticky illegal flag and stops issuing requests. The starting address comes from an input that must be stable while reset is low. The program and its data are loaded into memory from outside.

Top module: `lsc_core`

## Requirements
- R1: While reset is low, general registers 1 and 31 and the count and link registers are cleared, and the program counter loads `start_pc`. After reset the first request is a read at `start_pc`, with `mem_wr` low and `illegal` low.
- R2: Instruction bit k (k=0 is the MSB) is word bit 31-k. The primary opcode is bits 0..5, the target/source register is bits 6..10, the base register is bits 11..15, the second source is bits 16..20, and the signed 16-bit immediate is bits 16..31. Add-immediate (opcode 001110) writes base+sign-extended immediate into the target, and a base index of 0 reads as zero.
- R3: Opcode 011111 with bits 21..30 = 0110111100 writes (reg[bits 6..10] OR reg[bits 16..20]) into the register named by bits 11..15.
- R4: Load (opcode 100000) reads the word at base+sign-extended displacement, with base index 0 reading as zero. It writes that word into bits 31..0 of the target and clears bits 63..32.
- R5: Store (opcode 100100) writes the low 32 bits of the source register to the address formed as in R4.
- R6: Store-with-update (opcode 100101) adds the displacement to the base register value, with no zero substitution for index 0. It stores at that address and then writes the address back into the base register.
- R7: Opcode 010011 with bits 21..30 = 0000010000 is a branch to the link register. Let B0..B3 be bits 6..9 and let the condition bit be condition-word bit (bits 11..15) counted from its MSB. The condition passes if B0 is set or if the condition bit equals B1. When taken, the next address is the old link value with bits 1..0 cleared. When bit 31 is set, the link register then receives this instruction's address + 4.
- R8: When B2 is clear the branch first decrements the count register, and the count test passes when (count != 0) differs from B3. When B2 is set the count is untouched and the test passes. The branch is taken only if both tests pass.
- R9: Every non-branch instruction, and every branch not taken, advances the program counter by 4. Each instruction executes exactly once per visit.
- R10: A request stays unchanged (strobes, address, write data) until `mem_ready` is seen high at a clock edge. Read and write strobes are never high together.
- R11: An undecodable instruction word (for example opcode 011111 with an unlisted bits 21..30) sets `illegal`, which stays high. No later memory request is made and no later instruction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pc | input | 64 | First instruction address, held while in reset |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe (store) |
| mem_addr | output | 64 | Byte address of the word access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this clock edge |
| illegal | output | 1 | Undecodable instruction seen; core halted |

## Verification
The bench targets several errors that are easy to make. Loading a word with the top bit set catches a sign-extending load, because the next store built on that address leaves the low 4 GB. A store-with-update on register 0 catches a design that substitutes zero there, because the store lands at the wrong word. Two-pass loops built from a link-then-branch pattern catch a design that writes the link before reading the branch target: such a design falls through after one pass and the loop count reads 1. A not-taken branch whose target would re-enter an earlier loop catches inverted condition or count senses, either as a wrong count or as a hang. Variable memory latency, a total store count and a guarded word placed after the halting instruction expose skipped, repeated or unheld accesses.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int unsigned XLEN    = 64;
  localparam int unsigned ILEN    = 32;
  localparam int unsigned WLEN    = 32;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned NREG    = 1 << RIDX_W;
  localparam int unsigned CRW     = 32;
  localparam int unsigned STEP    = ILEN / 8;

  localparam logic [5:0] OPC_ADDI  = 6'b001110;
  localparam logic [5:0] OPC_LOADW = 6'b100000;
  localparam logic [5:0] OPC_STORW = 6'b100100;
  localparam logic [5:0] OPC_STORU = 6'b100101;
  localparam logic [5:0] OPC_GRP31 = 6'b011111;
  localparam logic [5:0] OPC_GRP19 = 6'b010011;
  localparam logic [9:0] XO_ORR    = 10'b0110111100;
  localparam logic [9:0] XO_BRLNK  = 10'b0000010000;

  typedef enum logic [2:0] {
    K_ADDI, K_ORR, K_LOADW, K_STORW, K_STORU, K_BRLNK, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [15:0]       imm;
    logic              lnk;
  } dec_t;

  typedef enum logic [1:0] {
    ST_FETCH, ST_EXEC, ST_MEM, ST_HALT
  } state_e;

  function automatic logic [XLEN-1:0] f_exts16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_zext_word(input logic [WLEN-1:0] w);
    return {{(XLEN-WLEN){1'b0}}, w};
  endfunction

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] pc);
    return pc + XLEN'(STEP);
  endfunction

  function automatic logic [XLEN-1:0] f_align(input logic [XLEN-1:0] a);
    return {a[XLEN-1:2], 2'b00};
  endfunction

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
  import lsc_pkg::*;
(
  input  logic [ILEN-1:0] ir,
  output dec_t            dec
);

  logic [5:0] opc;
  logic [9:0] xo;

  assign opc = ir[31:26];
  assign xo  = ir[10:1];

  always_comb begin
    dec.rt  = ir[25:21];
    dec.ra  = ir[20:16];
    dec.rb  = ir[15:11];
    dec.imm = ir[15:0];
    dec.lnk = ir[0];
    unique case (opc)
      OPC_ADDI:  dec.kind = K_ADDI;
      OPC_LOADW: dec.kind = K_LOADW;
      OPC_STORW: dec.kind = K_STORW;
      OPC_STORU: dec.kind = K_STORU;
      OPC_GRP31: dec.kind = (xo == XO_ORR)   ? K_ORR   : K_BAD;
      OPC_GRP19: dec.kind = (xo == XO_BRLNK) ? K_BRLNK : K_BAD;
      default:   dec.kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile
  import lsc_pkg::*;
#(
  parameter int unsigned CLR_LO = 1,
  parameter int unsigned CLR_HI = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]   rd_a,
  input  logic [RIDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]   rd_b,
  input  logic [RIDX_W-1:0] rd_c_idx,
  output logic [XLEN-1:0]   rd_c,
  input  logic              we,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_data
);

  logic [XLEN-1:0] rf [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic [XLEN-1:0] q;
    logic            hit;
    assign hit = we && (wr_idx == RIDX_W'(i));
    if (i == CLR_LO || i == CLR_HI) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (hit) q <= wr_data;
      end
    end
    assign rf[i] = q;
  end

  assign rd_a = rf[rd_a_idx];
  assign rd_b = rf[rd_b_idx];
  assign rd_c = rf[rd_c_idx];

  // a write is visible on every read port in the following cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rf[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/lsc_bru.sv
module lsc_bru
  import lsc_pkg::*;
(
  input  logic [4:0]      bo,
  input  logic [4:0]      bi,
  input  logic [CRW-1:0]  cr,
  input  logic [XLEN-1:0] ctr,
  input  logic [XLEN-1:0] lr,
  input  logic [XLEN-1:0] cia,
  output logic            taken,
  output logic            ctr_dec,
  output logic [XLEN-1:0] ctr_nxt,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] lr_nxt
);

  // field bit k of the big-endian numbered BO lives at bo[4-k]
  logic ignore_cond, cond_sense, skip_ctr, want_zero;
  logic cr_bit, ctr_ok, cond_ok;

  assign ignore_cond = bo[4];
  assign cond_sense  = bo[3];
  assign skip_ctr    = bo[2];
  assign want_zero   = bo[1];

  assign ctr_dec = !skip_ctr;
  assign ctr_nxt = skip_ctr ? ctr : ctr - XLEN'(1);
  assign ctr_ok  = skip_ctr || ((ctr_nxt != '0) ^ want_zero);
  assign cr_bit  = cr[CRW - 1 - int'(bi)];
  assign cond_ok = ignore_cond || (cr_bit == cond_sense);
  assign taken   = ctr_ok && cond_ok;
  assign target  = f_align(lr);
  assign lr_nxt  = f_seq(cia);

endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter logic [CRW-1:0] CR_INIT = 32'h8000_0000,
  parameter int unsigned    CLR_LO  = 1,
  parameter int unsigned    CLR_HI  = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] start_pc,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [XLEN-1:0] mem_addr,
  output logic [WLEN-1:0] mem_wdata,
  input  logic [WLEN-1:0] mem_rdata,
  input  logic            mem_ready,
  output logic            illegal
);

  state_e          state_q;
  logic [XLEN-1:0] pc_q, ctr_q, lr_q, ea_q;
  logic [ILEN-1:0] ir_q;
  logic [WLEN-1:0] wd_q;

  dec_t            dec;
  logic [XLEN-1:0] rd_a, rd_b, rd_c, base, ea_nxt;
  logic            rf_we;
  logic [RIDX_W-1:0] rf_widx;
  logic [XLEN-1:0] rf_wdata;

  logic            br_taken, br_ctr_dec;
  logic [XLEN-1:0] br_ctr_nxt, br_target, br_lr_nxt;

  // named events for the checks
  logic in_exec, mem_done, ev_seq_done, ev_br, ev_br_taken, ev_ctr_dec, ev_link;

  lsc_decode u_dec (.ir(ir_q), .dec(dec));

  lsc_regfile #(.CLR_LO(CLR_LO), .CLR_HI(CLR_HI)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (dec.ra),
    .rd_a     (rd_a),
    .rd_b_idx (dec.rb),
    .rd_b     (rd_b),
    .rd_c_idx (dec.rt),
    .rd_c     (rd_c),
    .we       (rf_we),
    .wr_idx   (rf_widx),
    .wr_data  (rf_wdata)
  );

  lsc_bru u_bru (
    .bo      (dec.rt),
    .bi      (dec.ra),
    .cr      (CR_INIT),
    .ctr     (ctr_q),
    .lr      (lr_q),
    .cia     (pc_q),
    .taken   (br_taken),
    .ctr_dec (br_ctr_dec),
    .ctr_nxt (br_ctr_nxt),
    .target  (br_target),
    .lr_nxt  (br_lr_nxt)
  );

  assign base   = (dec.ra == '0) ? '0 : rd_a;
  assign ea_nxt = ((dec.kind == K_STORU) ? rd_a : base) + f_exts16(dec.imm);

  assign in_exec     = (state_q == ST_EXEC);
  assign mem_done    = (state_q == ST_MEM) && mem_ready;
  assign ev_br       = in_exec && (dec.kind == K_BRLNK);
  assign ev_br_taken = ev_br && br_taken;
  assign ev_ctr_dec  = ev_br && br_ctr_dec;
  assign ev_link     = ev_br && dec.lnk;
  assign ev_seq_done = mem_done || (ev_br && !br_taken) ||
                       (in_exec && (dec.kind == K_ADDI || dec.kind == K_ORR));

  // register write port: execute-phase ALU results or memory-phase results
  always_comb begin
    rf_we    = 1'b0;
    rf_widx  = dec.rt;
    rf_wdata = '0;
    if (in_exec && dec.kind == K_ADDI) begin
      rf_we    = 1'b1;
      rf_wdata = base + f_exts16(dec.imm);
    end else if (in_exec && dec.kind == K_ORR) begin
      rf_we    = 1'b1;
      rf_widx  = dec.ra;
      rf_wdata = rd_c | rd_b;
    end else if (mem_done && dec.kind == K_LOADW) begin
      rf_we    = 1'b1;
      rf_wdata = f_zext_word(mem_rdata);
    end else if (mem_done && dec.kind == K_STORU) begin
      rf_we    = 1'b1;
      rf_widx  = dec.ra;
      rf_wdata = ea_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= start_pc;
      ir_q    <= '0;
      ctr_q   <= '0;
      lr_q    <= '0;
      ea_q    <= '0;
      wd_q    <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: if (mem_ready) begin
          ir_q    <= mem_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          unique case (dec.kind)
            K_ADDI, K_ORR: begin
              pc_q    <= f_seq(pc_q);
              state_q <= ST_FETCH;
            end
            K_BRLNK: begin
              pc_q  <= br_taken ? br_target : f_seq(pc_q);
              ctr_q <= br_ctr_nxt;
              if (dec.lnk) lr_q <= br_lr_nxt;
              state_q <= ST_FETCH;
            end
            K_LOADW, K_STORW, K_STORU: begin
              ea_q    <= ea_nxt;
              wd_q    <= rd_c[WLEN-1:0];
              state_q <= ST_MEM;
            end
            default: state_q <= ST_HALT;
          endcase
        end
        ST_MEM: if (mem_ready) begin
          pc_q    <= f_seq(pc_q);
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign mem_rd    = (state_q == ST_FETCH) || (state_q == ST_MEM && dec.kind == K_LOADW);
  assign mem_wr    = (state_q == ST_MEM) && (dec.kind == K_STORW || dec.kind == K_STORU);
  assign mem_addr  = (state_q == ST_MEM) ? ea_q : pc_q;
  assign mem_wdata = wd_q;
  assign illegal   = (state_q == ST_HALT);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      mem_rd == $past(mem_rd) && mem_wr == $past(mem_wr) &&
      mem_addr == $past(mem_addr) && mem_wdata == $past(mem_wdata));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_rd && !mem_wr);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  p_seq_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_done |=> pc_q == $past(pc_q) + XLEN'(STEP));

  p_br_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_br_taken |=> pc_q[1:0] == 2'b00 && pc_q[XLEN-1:2] == $past(lr_q[XLEN-1:2]));

  p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link |=> lr_q == $past(pc_q) + XLEN'(STEP));

  p_ctr_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctr_dec |=> ctr_q == $past(ctr_q) - XLEN'(1));

  p_ctr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ctr_dec |=> ctr_q == $past(ctr_q));

endmodule

// File: tb/test_lsc_core.sv
module test_lsc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] start_pc = 64'h100;
  logic        mem_rd, mem_wr, illegal;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [1024];
  int wait_n = 0, lat = 0, stalls = 0, hold_err = 0, bad_addr = 0, wr_count = 0;
  int exp_writes = 0;
  logic pend = 1'b0, pend_rd, pend_wr;
  logic [63:0] pend_addr;
  logic [63:0] pa;

  localparam logic [31:0] FILL = 32'hDEAD_BEEF;

  always #5ns clk = ~clk;

  lsc_core i_lsc_core (
    .clk(clk), .rst_n(rst_n), .start_pc(start_pc),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .illegal(illegal)
  );

  // behavioural memory: latency rotates 0,1,2 wait cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0; wait_n = 0; pend = 1'b0;
    end else begin
      if (pend && !(mem_rd == pend_rd && mem_wr == pend_wr && mem_addr == pend_addr))
        hold_err++;
      if (mem_rd || mem_wr) begin
        if (mem_addr[63:32] != 0 || mem_addr[1:0] != 0) bad_addr++;
        if (wait_n >= lat) begin
          mem_ready = 1'b1;
          if (mem_rd) mem_rdata = mem[mem_addr[11:2]];
          if (mem_wr) begin mem[mem_addr[11:2]] = mem_wdata; wr_count++; end
          wait_n = 0; lat = (lat == 2) ? 0 : lat + 1; pend = 1'b0;
        end else begin
          mem_ready = 1'b0; wait_n++; stalls++;
          pend = 1'b1; pend_rd = mem_rd; pend_wr = mem_wr; pend_addr = mem_addr;
        end
      end else begin
        mem_ready = 1'b0; pend = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] enc_d(input int op, input int t, input int a, input logic [15:0] imm);
    return {6'(op), 5'(t), 5'(a), imm};
  endfunction
  function automatic logic [31:0] enc_or(input int s, input int a, input int b);
    return {6'd31, 5'(s), 5'(a), 5'(b), 10'd444, 1'b0};
  endfunction
  function automatic logic [31:0] enc_br(input logic [4:0] bo, input int bi, input logic lk);
    return {6'd19, bo, 5'(bi), 5'd0, 10'd16, lk};
  endfunction

  task automatic emit(input logic [31:0] w);
    mem[pa[11:2]] = w;
    pa = pa + 4;
  endtask
  task automatic st(input int s, input int a, input logic [15:0] d);
    emit(enc_d(36, s, a, d)); exp_writes++;
  endtask
  task automatic addi(input int t, input int a, input logic [15:0] v);
    emit(enc_d(14, t, a, v));
  endtask

  task automatic build_program;
    for (int i = 0; i < 1024; i++) mem[i] = FILL;
    mem[12'h900 >> 2] = 32'h8000_0A00;
    pa = 64'h100;
    st(1, 0, 16'h0800);  st(31, 0, 16'h0804);
    addi(0, 0, 16'h0055); addi(6, 0, 16'h0001); st(6, 0, 16'h0808);
    addi(7, 0, 16'hFFFE); addi(8, 7, 16'h7FFF);
    st(8, 0, 16'h080C);  st(7, 0, 16'h0810);
    addi(9, 0, 16'h00F0); addi(10, 0, 16'h000F);
    emit(enc_or(9, 11, 10));
    st(11, 0, 16'h0814); st(9, 0, 16'h0818);
    addi(13, 0, 16'h0910);
    emit(enc_d(32, 14, 13, 16'hFFF0));
    st(6, 14, 16'h0000); st(14, 0, 16'h081C);
    addi(16, 0, 16'h0A80);
    emit(enc_d(37, 8, 16, 16'h0008)); exp_writes++;
    st(16, 0, 16'h0820);
    emit(enc_d(37, 6, 0, 16'h03AB)); exp_writes++;
    st(0, 0, 16'h0824);
    addi(20, 0, 16'h0000);
    emit(enc_br(5'b00100, 0, 1'b1)); addi(20, 20, 16'h0001);
    emit(enc_br(5'b10100, 0, 1'b1)); st(20, 0, 16'h0828);
    addi(23, 0, 16'h0000);
    emit(enc_br(5'b00100, 0, 1'b1)); addi(23, 23, 16'h0001);
    emit(enc_br(5'b01100, 0, 1'b1)); st(23, 0, 16'h082C);
    emit(enc_br(5'b01100, 1, 1'b0)); addi(25, 0, 16'h0009); st(25, 0, 16'h0830);
    emit(enc_br(5'b10010, 0, 1'b0)); addi(26, 0, 16'h0003); st(26, 0, 16'h0834);
    addi(24, 0, 16'h0000);
    emit(enc_br(5'b00100, 0, 1'b1)); addi(24, 24, 16'h0001);
    emit(enc_br(5'b10000, 0, 1'b1)); st(24, 0, 16'h0838);
    emit(32'h7C00_0000);
    emit(enc_d(36, 6, 0, 16'h083C));
  endtask

  function automatic logic [63:0] rdw(input logic [11:0] a);
    return {32'h0, mem[a[11:2]]};
  endfunction

  task automatic t_reset_state;
    @(negedge clk);
    chk("R1", "first fetch strobe", {63'h0, mem_rd}, 64'h1);
    chk("R1", "first fetch address", mem_addr, 64'h100);
    chk("R1", "no write in reset", {63'h0, mem_wr}, 64'h0);
    chk("R1", "illegal low", {63'h0, illegal}, 64'h0);
  endtask

  task automatic t_run;
    int n = 0;
    while (!illegal && n < 20000) begin @(negedge clk); n++; end
    chk("R11", "program reached halt", {63'h0, illegal}, 64'h1);
  endtask

  task automatic t_reset_regs;
    chk("R1", "r1 cleared", rdw(12'h800), 64'h0);
    chk("R1", "r31 cleared", rdw(12'h804), 64'h0);
  endtask
  task automatic t_addi;
    chk("R2", "base 0 reads zero", rdw(12'h808), 64'h1);
    chk("R2", "sign-extended sum", rdw(12'h80C), 64'h7FFD);
  endtask
  task automatic t_or;
    chk("R3", "OR result in RA field", rdw(12'h814), 64'hFF);
    chk("R3", "RS register untouched", rdw(12'h818), 64'hF0);
  endtask
  task automatic t_load;
    chk("R4", "loaded word value", rdw(12'h81C), 64'h8000_0A00);
    chk("R4", "zero-extended base store", rdw(12'hA00), 64'h1);
    chk("R4", "no address above 4 GB", 64'(bad_addr), 64'h0);
  endtask
  task automatic t_store;
    chk("R5", "low half of negative value", rdw(12'h810), 64'hFFFF_FFFE);
  endtask
  task automatic t_update;
    chk("R6", "update store data", rdw(12'hA88), 64'h7FFD);
    chk("R6", "update base written back", rdw(12'h820), 64'hA88);
    chk("R6", "index 0 uses register value", rdw(12'h400), 64'h1);
    chk("R6", "r0 holds effective address", rdw(12'h824), 64'h400);
  endtask
  task automatic t_branch;
    chk("R7", "always-taken link loop count", rdw(12'h828), 64'h2);
    chk("R7", "condition-true loop count", rdw(12'h82C), 64'h2);
    chk("R7", "condition-false falls through", rdw(12'h830), 64'h9);
  endtask
  task automatic t_count;
    chk("R8", "count-zero test not taken", rdw(12'h834), 64'h3);
    chk("R8", "count-nonzero loop count", rdw(12'h838), 64'h2);
  endtask
  task automatic t_sequence;
    chk("R9", "each store ran once", 64'(wr_count), 64'(exp_writes));
  endtask
  task automatic t_handshake;
    chk("R10", "requests held while stalled", 64'(hold_err), 64'h0);
    chk("R10", "stalls occurred", 64'(stalls > 0), 64'h1);
  endtask
  task automatic t_halt;
    int busy = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !illegal) busy++;
    end
    chk("R11", "quiet and flagged after halt", 64'(busy), 64'h0);
    chk("R11", "word after halt not stored", rdw(12'h83C), {32'h0, FILL});
  endtask

  initial begin
    build_program();
    repeat (3) @(posedge clk);
    t_reset_state();
    @(negedge clk) rst_n = 1'b1;
    t_run();
    t_reset_regs();
    t_addi();
    t_or();
    t_load();
    t_store();
    t_update();
    t_branch();
    t_count();
    t_sequence();
    t_handshake();
    t_halt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(1_500_000ns);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule